// File: doc/BRIEF.md
# Network packet timestamp capture unit

This block listens, without touching the data, to the transmit and receive nibble streams of a media-independent interface. A free-running local time counter holds 32 bits of seconds and 32 bits of nanoseconds and advances by a programmable nanosecond step on every clock. When a frame's start-of-frame delimiter completes on either stream, the unit takes a snapshot of the counter. The frame is then parsed far enough to decide whether it is a precision-time-protocol Sync or Delay_Req message. If it is, the snapshot is kept together with the message's sequence number and its 80-bit source port identity.

Each kept capture is tagged as t1, t2, t3 or t4. The tag comes from the node's configured role and from the direction the frame travelled. The capture is placed in a one-entry holding register for that direction, with a valid flag and an acknowledge input, so that software can pair the timestamp with the right message. In the master role the transmit-side t1 value is the one that software puts into the later Follow_Up message. The transmit and receive directions have their own parser and their own holding register.

Top module: `ptp_stamp_unit`

## Requirements
- R1: After reset `time_now` is zero. On each clock the nanosecond half (bits 31:0) adds `ns_step`. When the sum reaches 1,000,000,000, that amount is subtracted and the seconds half (bits 63:32) increments. The nanosecond half is always below 1,000,000,000.
- R2: Nibbles are taken low nibble first within each byte. A start-of-frame delimiter is a nibble 0xD that follows one or more 0x5 preamble nibbles. The captured timestamp equals `time_now` in the cycle in which that 0xD nibble is sampled.
- R3: Bytes are counted from 0 at the first byte after the delimiter. A frame qualifies only if bytes 12 and 13 are 0x88 and 0xF7, and the low nibble of byte 14 is 0 (Sync) or 1 (Delay_Req). The high nibble of byte 14 is ignored. Any other frame produces no capture.
- R4: Kind encoding is 0 = t1, 1 = t2, 2 = t3, 3 = t4. In the master role (`role_master`=1), a transmitted Sync is captured as t1 and a received Delay_Req as t4. In the slave role, a received Sync is t2 and a transmitted Delay_Req is t3. A transmitted Delay_Req in the master role, or a transmitted Sync in the slave role, is not captured. The same rule applies to received frames in the opposite combination.
- R5: The captured sequence number is bytes 44 and 45, with byte 44 as the high byte. The captured port identity is bytes 34 to 43, with byte 34 in bits 79:72.
- R6: If the enable of a stream drops before the high nibble of byte 45 has been sampled, no capture is made.
- R7: The valid flag stays high and the held timestamp, sequence, port and kind stay unchanged until the acknowledge pulse. A one-cycle acknowledge clears both valid and overflow on the next edge. All valid and overflow flags are low after reset.
- R8: If a capture arrives while that direction's entry is valid and not being acknowledged, the overflow flag is set and stays set until acknowledge. The new capture is dropped and the held entry is kept.
- R9: The transmit and receive entries are independent. A capture or acknowledge on one side does not change the other side.
- R10: The valid flag rises on the second rising edge after the edge that samples the high nibble of byte 45. It is still low after the first of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the nibble streams |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| ns_step | input | STEP_W | Nanoseconds added to the time counter per clock |
| tx_en | input | 1 | Transmit enable of the observed stream |
| txd | input | 4 | Transmit data nibble |
| rx_dv | input | 1 | Receive data valid of the observed stream |
| rxd | input | 4 | Receive data nibble |
| tx_ack | input | 1 | Software acknowledge of the transmit entry |
| rx_ack | input | 1 | Software acknowledge of the receive entry |
| time_now | output | 64 | Local time counter, {seconds, nanoseconds} |
| tx_valid | output | 1 | Transmit entry holds a capture |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_kind | output | 2 | Transmit capture kind (t1 or t3) |
| tx_ts | output | 64 | Transmit capture timestamp |
| tx_seq | output | 16 | Transmit capture sequence number |
| tx_port | output | 80 | Transmit capture source port identity |
| rx_valid | output | 1 | Receive entry holds a capture |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_kind | output | 2 | Receive capture kind (t2 or t4) |
| rx_ts | output | 64 | Receive capture timestamp |
| rx_seq | output | 16 | Receive capture sequence number |
| rx_port | output | 80 | Receive capture source port identity |

## Verification
Some rules are checked on every cycle: the nanosecond range and the seconds carry of the counter, and that a rise of valid or overflow always follows a capture pulse. Also checked on every cycle are that held entries stay stable while unacknowledged, that acknowledge clears overflow, that capture pulses last one cycle, and that each side reports only its own two kinds. Other behaviour can only be shown by the bench's frames, because it depends on the frame contents and on when each frame ends. This covers the exact timestamp taken at the delimiter, the byte positions of the type, sequence and port fields, and rejection by EtherType, message type or role. It also covers aborted frames, the two-edge latency and the independence of the two sides.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 32;
  localparam int TS_W   = SEC_W + NS_W;
  localparam int SEQ_W  = 16;
  localparam int PORT_W = 80;

  typedef enum logic [1:0] {
    STAMP_T1 = 2'd0,
    STAMP_T2 = 2'd1,
    STAMP_T3 = 2'd2,
    STAMP_T4 = 2'd3
  } stamp_kind_e;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_PRE,
    PS_BODY,
    PS_SKIP
  } parse_state_e;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [SEQ_W-1:0]  seq;
    logic [PORT_W-1:0] port;
    logic              is_dreq;
  } capture_t;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [SEQ_W-1:0]  seq;
    logic [PORT_W-1:0] port;
    stamp_kind_e       kind;
  } stamp_rec_t;
endpackage

// File: rtl/ptp_time_base.sv
module ptp_time_base
  import ptp_stamp_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  output logic [TS_W-1:0]   time_now
);
  localparam logic [NS_W:0] NS_LIMIT = (NS_W+1)'(1_000_000_000);

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [NS_W-1:0]  ns_q, ns_d;
  logic [NS_W:0]    ns_sum;

  always_comb begin
    ns_sum = {1'b0, ns_q} + (NS_W+1)'(step);
    sec_d  = sec_q;
    if (ns_sum >= NS_LIMIT) begin
      ns_d  = NS_W'(ns_sum - NS_LIMIT);
      sec_d = sec_q + 1'b1;
    end else begin
      ns_d  = ns_sum[NS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
    end
  end

  assign time_now = {sec_q, ns_q};

  assert_ns_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ns_q} < NS_LIMIT);

  assert_sec_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q != $past(sec_q)) |-> ((NS_W+1)'(ns_q) < (NS_W+1)'($past(step))));
endmodule

// File: rtl/ptp_frame_parse.sv
module ptp_frame_parse
  import ptp_stamp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [3:0]      nib,
  input  logic [TS_W-1:0] time_now,
  output logic            cap_fire,
  output capture_t        cap
);
  localparam logic [3:0] NIB_PRE = 4'h5;
  localparam logic [3:0] NIB_SFD = 4'hD;
  localparam logic [7:0] ETH_HI  = 8'h88;
  localparam logic [7:0] ETH_LO  = 8'hF7;
  localparam int         CNT_W   = 6;

  parse_state_e     st_q, st_d;
  logic             phase_q, phase_d;
  logic [3:0]       lo_q, lo_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic             fire_q, fire_d;
  logic             ts_ld;
  capture_t         cap_q, cap_d;
  logic [7:0]       byte_w;

  assign byte_w = {nib, lo_q};

  always_comb begin
    st_d    = st_q;
    phase_d = phase_q;
    lo_d    = lo_q;
    bcnt_d  = bcnt_q;
    fire_d  = 1'b0;
    ts_ld   = 1'b0;
    cap_d   = cap_q;
    case (st_q)
      PS_IDLE: begin
        if (en) st_d = (nib == NIB_PRE) ? PS_PRE : PS_SKIP;
      end
      PS_PRE: begin
        if (!en) begin
          st_d = PS_IDLE;
        end else if (nib == NIB_SFD) begin
          st_d    = PS_BODY;
          ts_ld   = 1'b1;
          phase_d = 1'b0;
          bcnt_d  = '0;
        end else if (nib != NIB_PRE) begin
          st_d = PS_SKIP;
        end
      end
      PS_BODY: begin
        if (!en) begin
          st_d = PS_IDLE;
        end else if (!phase_q) begin
          lo_d    = nib;
          phase_d = 1'b1;
        end else begin
          phase_d = 1'b0;
          bcnt_d  = bcnt_q + 1'b1;
          if (bcnt_q == CNT_W'(12) && byte_w != ETH_HI) st_d = PS_SKIP;
          if (bcnt_q == CNT_W'(13) && byte_w != ETH_LO) st_d = PS_SKIP;
          if (bcnt_q == CNT_W'(14)) begin
            if (byte_w[3:1] != 3'b000) st_d = PS_SKIP;
            cap_d.is_dreq = byte_w[0];
          end
          if (bcnt_q >= CNT_W'(34) && bcnt_q <= CNT_W'(43))
            cap_d.port = {cap_q.port[PORT_W-9:0], byte_w};
          if (bcnt_q == CNT_W'(44) || bcnt_q == CNT_W'(45))
            cap_d.seq = {cap_q.seq[7:0], byte_w};
          if (bcnt_q == CNT_W'(45)) begin
            fire_d = 1'b1;
            st_d   = PS_SKIP;
          end
        end
      end
      default: begin
        if (!en) st_d = PS_IDLE;
      end
    endcase
    if (ts_ld) cap_d.ts = time_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_IDLE;
      phase_q <= 1'b0;
      lo_q    <= '0;
      bcnt_q  <= '0;
      fire_q  <= 1'b0;
      cap_q   <= '0;
    end else begin
      st_q    <= st_d;
      phase_q <= phase_d;
      lo_q    <= lo_d;
      bcnt_q  <= bcnt_d;
      fire_q  <= fire_d;
      cap_q   <= cap_d;
    end
  end

  assign cap_fire = fire_q;
  assign cap      = cap_q;

  assert_fire_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> !cap_fire);

  assert_fire_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |-> $past(en));
endmodule

// File: rtl/ptp_stamp_hold.sv
module ptp_stamp_hold
  import ptp_stamp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  stamp_rec_t load_rec,
  input  logic       ack,
  output logic       valid,
  output logic       ovf,
  output stamp_rec_t rec
);
  logic       valid_q, valid_d;
  logic       ovf_q, ovf_d;
  logic       take;
  stamp_rec_t rec_q;

  always_comb begin
    take    = load && (!valid_q || ack);
    valid_d = valid_q;
    if (take)     valid_d = 1'b1;
    else if (ack) valid_d = 1'b0;
    ovf_d = ovf_q | (load && valid_q);
    if (ack) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rec_q <= '0;
    else if (take) rec_q <= load_rec;
  end

  assign valid = valid_q;
  assign ovf   = ovf_q;
  assign rec   = rec_q;

  assert_valid_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(load));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ack) |=> $stable(rec_q));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ovf_q);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(load && valid_q && !ack));
endmodule

// File: rtl/ptp_stamp_unit.sv
module ptp_stamp_unit
  import ptp_stamp_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_master,
  input  logic [STEP_W-1:0] ns_step,
  input  logic              tx_en,
  input  logic [3:0]        txd,
  input  logic              rx_dv,
  input  logic [3:0]        rxd,
  input  logic              tx_ack,
  input  logic              rx_ack,
  output logic [TS_W-1:0]   time_now,
  output logic              tx_valid,
  output logic              tx_ovf,
  output logic [1:0]        tx_kind,
  output logic [TS_W-1:0]   tx_ts,
  output logic [SEQ_W-1:0]  tx_seq,
  output logic [PORT_W-1:0] tx_port,
  output logic              rx_valid,
  output logic              rx_ovf,
  output logic [1:0]        rx_kind,
  output logic [TS_W-1:0]   rx_ts,
  output logic [SEQ_W-1:0]  rx_seq,
  output logic [PORT_W-1:0] rx_port
);
  localparam int NPATH = 2;

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  ptp_time_base #(.STEP_W(STEP_W)) i_time (
    .clk      (clk),
    .rst_n    (srst_n),
    .step     (ns_step),
    .time_now (time_now)
  );

  logic [NPATH-1:0] en_a;
  logic [3:0]       nib_a [NPATH];
  logic [NPATH-1:0] ack_a;
  logic [NPATH-1:0] valid_a;
  logic [NPATH-1:0] ovf_a;
  stamp_rec_t       rec_a [NPATH];

  assign en_a     = {rx_dv, tx_en};
  assign nib_a[0] = txd;
  assign nib_a[1] = rxd;
  assign ack_a    = {rx_ack, tx_ack};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic        fire;
    capture_t    cap;
    logic        want_dreq;
    logic        accept;
    stamp_rec_t  lrec;
    stamp_kind_e kind;

    ptp_frame_parse i_parse (
      .clk      (clk),
      .rst_n    (srst_n),
      .en       (en_a[p]),
      .nib      (nib_a[p]),
      .time_now (time_now),
      .cap_fire (fire),
      .cap      (cap)
    );

    if (p == 0) begin : g_tx
      assign want_dreq = !role_master;
      assign kind      = role_master ? STAMP_T1 : STAMP_T3;
    end else begin : g_rx
      assign want_dreq = role_master;
      assign kind      = role_master ? STAMP_T4 : STAMP_T2;
    end

    assign accept    = fire && (cap.is_dreq == want_dreq);
    assign lrec.ts   = cap.ts;
    assign lrec.seq  = cap.seq;
    assign lrec.port = cap.port;
    assign lrec.kind = kind;

    ptp_stamp_hold i_hold (
      .clk      (clk),
      .rst_n    (srst_n),
      .load     (accept),
      .load_rec (lrec),
      .ack      (ack_a[p]),
      .valid    (valid_a[p]),
      .ovf      (ovf_a[p]),
      .rec      (rec_a[p])
    );
  end

  assign tx_valid = valid_a[0];
  assign tx_ovf   = ovf_a[0];
  assign tx_kind  = rec_a[0].kind;
  assign tx_ts    = rec_a[0].ts;
  assign tx_seq   = rec_a[0].seq;
  assign tx_port  = rec_a[0].port;
  assign rx_valid = valid_a[1];
  assign rx_ovf   = ovf_a[1];
  assign rx_kind  = rec_a[1].kind;
  assign rx_ts    = rec_a[1].ts;
  assign rx_seq   = rec_a[1].seq;
  assign rx_port  = rec_a[1].port;

  assert_tx_kind_R4: assert property (@(posedge clk) disable iff (!srst_n)
    tx_valid |-> (tx_kind == STAMP_T1 || tx_kind == STAMP_T3));

  assert_rx_kind_R4: assert property (@(posedge clk) disable iff (!srst_n)
    rx_valid |-> (rx_kind == STAMP_T2 || rx_kind == STAMP_T4));

  assert_side_apart_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid && !tx_ack && !g_path[0].accept) |=> $stable(tx_seq));
endmodule

// File: tb/test_ptp_stamp_unit.sv
module test_ptp_stamp_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        role_master;
  logic [31:0] ns_step;
  logic        tx_en, rx_dv, tx_ack, rx_ack;
  logic [3:0]  txd, rxd;
  logic [63:0] time_now, tx_ts, rx_ts;
  logic        tx_valid, tx_ovf, rx_valid, rx_ovf;
  logic [1:0]  tx_kind, rx_kind;
  logic [15:0] tx_seq, rx_seq;
  logic [79:0] tx_port, rx_port;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptp_stamp_unit #(.STEP_W(32)) i_ptp_stamp_unit (
    .clk(clk), .rst_n(rst_n), .role_master(role_master), .ns_step(ns_step),
    .tx_en(tx_en), .txd(txd), .rx_dv(rx_dv), .rxd(rxd),
    .tx_ack(tx_ack), .rx_ack(rx_ack), .time_now(time_now),
    .tx_valid(tx_valid), .tx_ovf(tx_ovf), .tx_kind(tx_kind), .tx_ts(tx_ts),
    .tx_seq(tx_seq), .tx_port(tx_port),
    .rx_valid(rx_valid), .rx_ovf(rx_ovf), .rx_kind(rx_kind), .rx_ts(rx_ts),
    .rx_seq(rx_seq), .rx_port(rx_port)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] tadd(input logic [63:0] t, input int k, input logic [31:0] st);
    logic [63:0] tot;
    tot = {32'd0, t[31:0]} + 64'(k) * 64'(st);
    return {t[63:32] + 32'(tot / 64'd1_000_000_000), 32'(tot % 64'd1_000_000_000)};
  endfunction

  function automatic logic [1:0] kind_exp(input bit path, input bit master);
    if (!path) return master ? 2'd0 : 2'd2;
    return master ? 2'd3 : 2'd1;
  endfunction

  function automatic bit wanted(input bit path, input bit master, input logic [15:0] et,
                                input logic [7:0] mt);
    if (et != 16'h88F7) return 0;
    if (mt[3:1] != 3'b000) return 0;
    return path ? (mt[0] == master) : (mt[0] == !master);
  endfunction

  task automatic drive(input bit path, input bit en, input logic [3:0] n);
    @(negedge clk);
    if (!path) begin tx_en = en; txd = n; end
    else       begin rx_dv = en; rxd = n; end
  endtask

  // Ends right after the last nibble has been driven; enable still high.
  task automatic send(input bit path, input logic [15:0] et, input logic [7:0] mt,
                      input logic [15:0] seq, input logic [79:0] port, input int nbytes,
                      output logic [63:0] ts_exp);
    logic [7:0] fb [48];
    for (int i = 0; i < 48; i++) fb[i] = 8'($urandom);
    fb[12] = et[15:8];
    fb[13] = et[7:0];
    fb[14] = mt;
    for (int i = 0; i < 10; i++) fb[34+i] = port[79-8*i -: 8];
    fb[44] = seq[15:8];
    fb[45] = seq[7:0];
    for (int i = 0; i < 15; i++) drive(path, 1'b1, 4'h5);
    drive(path, 1'b1, 4'hD);
    ts_exp = time_now;
    for (int i = 0; i < nbytes; i++) begin
      drive(path, 1'b1, fb[i][3:0]);
      drive(path, 1'b1, fb[i][7:4]);
    end
  endtask

  task automatic idle(input bit path);
    drive(path, 1'b0, 4'h0);
  endtask

  task automatic ack(input bit path);
    @(negedge clk);
    if (!path) tx_ack = 1'b1; else rx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
    rx_ack = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] t0, ts1, ts2;
    logic        vpath;
    logic        vmaster;
    logic [7:0]  vmt;
    logic [15:0] vet, vseq;
    logic [79:0] vport;
    logic [1:0]  pk;
    int          seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; role_master = 1'b1; ns_step = 32'd300_000_007;
    tx_en = 0; rx_dv = 0; txd = 0; rxd = 0; tx_ack = 0; rx_ack = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset time", 128'(time_now), 128'd0);
    chk("R7 reset tx_valid", 128'(tx_valid), 128'd0);
    chk("R7 reset rx_valid", 128'(rx_valid), 128'd0);
    chk("R7 reset ovf", 128'({tx_ovf, rx_ovf}), 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: large step forces frequent seconds carries
    t0 = time_now;
    repeat (17) @(negedge clk);
    chk("R1 wrap count", 128'(time_now), 128'(tadd(t0, 17, ns_step)));
    @(negedge clk); ns_step = 32'd12;
    t0 = time_now;
    repeat (29) @(negedge clk);
    chk("R1 small step", 128'(time_now), 128'(tadd(t0, 29, 32'd12)));

    // R2 R4 R5 R10: master transmits Sync
    send(1'b0, 16'h88F7, 8'h00, 16'hBEEF, 80'h0102_0304_0506_0708_090A, 48, ts1);
    // last needed nibble was byte 45 high; 2 more bytes already sent, so valid is up
    idle(1'b0);
    chk("R10 tx valid after frame", 128'(tx_valid), 128'd1);
    chk("R2 tx ts", 128'(tx_ts), 128'(ts1));
    chk("R4 kind t1", 128'(tx_kind), 128'd0);
    chk("R5 seq", 128'(tx_seq), 128'hBEEF);
    chk("R5 port", 128'(tx_port), 128'h0102_0304_0506_0708_090A);

    // R10 exact latency: stop after byte 45
    ack(1'b0);
    send(1'b1, 16'h88F7, 8'h01, 16'h1234, 80'hAA55_0000_1111_2222_3333, 46, ts2);
    idle(1'b1);
    chk("R10 not yet valid", 128'(rx_valid), 128'd0);
    @(negedge clk);
    chk("R10 valid on second edge", 128'(rx_valid), 128'd1);
    chk("R4 kind t4", 128'(rx_kind), 128'd3);
    chk("R2 rx ts", 128'(rx_ts), 128'(ts2));

    // R9: tx capture while rx held, then ack tx only
    send(1'b0, 16'h88F7, 8'h10, 16'h0042, 80'h1, 48, ts1);
    idle(1'b0);
    chk("R3 high nibble ignored", 128'(tx_valid), 128'd1);
    chk("R9 rx kept", 128'({rx_valid, rx_ovf, rx_seq}), 128'({1'b1, 1'b0, 16'h1234}));
    ack(1'b0);
    chk("R9 tx cleared", 128'(tx_valid), 128'd0);
    chk("R9 rx still valid", 128'({rx_valid, rx_seq}), 128'({1'b1, 16'h1234}));
    ack(1'b1);
    chk("R7 rx cleared", 128'(rx_valid), 128'd0);

    // R3: wrong EtherType and wrong message type
    send(1'b0, 16'h88F6, 8'h00, 16'h5, 80'h5, 48, ts1);
    idle(1'b0); repeat (2) @(negedge clk);
    chk("R3 ethertype rejected", 128'(tx_valid), 128'd0);
    send(1'b0, 16'h88F7, 8'h08, 16'h6, 80'h6, 48, ts1);
    idle(1'b0); repeat (2) @(negedge clk);
    chk("R3 msgtype rejected", 128'(tx_valid), 128'd0);

    // R4: master transmitting Delay_Req is not captured
    send(1'b0, 16'h88F7, 8'h01, 16'h7, 80'h7, 48, ts1);
    idle(1'b0); repeat (2) @(negedge clk);
    chk("R4 role mismatch", 128'(tx_valid), 128'd0);

    // R6: abort before byte 45 high nibble
    send(1'b0, 16'h88F7, 8'h00, 16'h8, 80'h8, 45, ts1);
    drive(1'b0, 1'b1, 4'h3);
    idle(1'b0); repeat (3) @(negedge clk);
    chk("R6 abort no capture", 128'(tx_valid), 128'd0);

    // R8: overflow keeps the first capture
    send(1'b0, 16'h88F7, 8'h00, 16'hAAAA, 80'hA, 48, ts1);
    idle(1'b0); idle(1'b0);
    send(1'b0, 16'h88F7, 8'h00, 16'hBBBB, 80'hB, 48, ts2);
    idle(1'b0); idle(1'b0);
    chk("R8 overflow set", 128'({tx_valid, tx_ovf}), 128'({1'b1, 1'b1}));
    chk("R8 first kept", 128'({tx_seq, tx_ts}), 128'({16'hAAAA, ts1}));
    ack(1'b0);
    chk("R7 ack clears both", 128'({tx_valid, tx_ovf}), 128'd0);

    // Slave role: R4 t2 and t3
    role_master = 1'b0;
    send(1'b1, 16'h88F7, 8'h00, 16'h0C0C, 80'hC, 48, ts2);
    idle(1'b1);
    chk("R4 kind t2", 128'({rx_valid, rx_kind}), 128'({1'b1, 2'd1}));
    ack(1'b1);
    send(1'b0, 16'h88F7, 8'h01, 16'h0D0D, 80'hD, 48, ts1);
    idle(1'b0);
    chk("R4 kind t3", 128'({tx_valid, tx_kind, tx_ts}), 128'({1'b1, 2'd2, ts1}));
    ack(1'b0);

    // Random mix, checked against bench rules R3 R4 R5
    for (int n = 0; n < 30; n++) begin
      vpath   = 1'($urandom);
      vmaster = 1'($urandom);
      role_master = vmaster;
      case ($urandom % 4)
        0: vmt = 8'h00;
        1: vmt = 8'h01;
        2: vmt = 8'h02;
        default: vmt = {4'($urandom), 3'b000, 1'($urandom)};
      endcase
      vet   = ($urandom % 5 == 0) ? 16'($urandom) : 16'h88F7;
      vseq  = 16'($urandom);
      vport = {16'($urandom), 32'($urandom), 32'($urandom)};
      send(vpath, vet, vmt, vseq, vport, 48, ts1);
      idle(vpath); @(negedge clk);
      pk = kind_exp(vpath, vmaster);
      if (wanted(vpath, vmaster, vet, vmt)) begin
        if (!vpath) chk("R5 random tx", 128'({tx_valid, tx_kind, tx_seq, tx_port[31:0]}),
                        128'({1'b1, pk, vseq, vport[31:0]}));
        else        chk("R5 random rx", 128'({rx_valid, rx_kind, rx_seq, rx_port[31:0]}),
                        128'({1'b1, pk, vseq, vport[31:0]}));
        ack(vpath);
      end else begin
        chk("R3 random ignored", 128'({tx_valid, rx_valid}), 128'd0);
      end
    end
    summary();
  end
endmodule